// File: doc/BRIEF.md
# SPI Status Edge Interrupt Cause Unit

This block sits beside an SPI controller and converts its thirteen level status signals into sticky interrupt causes. A cause bit latches only when the status bit it watches goes from 0 to 1. A status bit that is already high, or that stays high, does not latch a cause again after software has cleared it. A mask register selects which latched causes drive the single level interrupt line. Software clears causes by writing ones to the cause register, and it can read both the cause and mask registers back.

The typical driver sequence is short. Software first reads the controller status and skips the wait if the condition it needs is already true. Otherwise it sets the mask to the one condition it waits for, takes the interrupt, writes the mask back to zero and clears the causes it saw. Because the unit fires on edges only, it never raises an interrupt for a condition that was already true when the wait started.

Top module: `spi_irq_cause`

## Requirements
- R1: After a synchronous active-low reset, the cause register, the mask register and the interrupt output are all 0.
- R2: When a status bit is 0 at one rising clock edge and 1 at the next, its cause bit reads 1 after that second edge and stays 1 until it is cleared.
- R3: A status bit that stays 1 does not set its cause bit again after the cause has been cleared. It can set the cause again only after it has gone back to 0 and then risen.
- R4: Writing the cause register clears every bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged. Writing all ones clears every cause.
- R5: When a rising edge and a clear of the same bit fall in the same cycle, the cause bit ends up set.
- R6: Cause bits latch whatever the mask value is.
- R7: The interrupt output is the OR of the bitwise AND of cause and mask. A mask write takes effect after that clock edge, and writing 0 to the mask drops the interrupt without changing any cause.
- R8: The cause and mask readback outputs always show the current register contents. A mask write loads all 13 bits.
- R9: Bit positions follow the status vector: 0 is transfer done, 1 is transfer ready, 2 is read-FIFO ready, 3 is write-FIFO ready, 4 is read-FIFO empty, 5 is read-FIFO full, 6 is write-FIFO empty, 7 is write-FIFO full, 8 to 11 are the FIFO underflow and overflow flags, and 12 is address-not-configured. Status bit i drives cause bit i only.
- R10: The stored previous status resets to 0. A status bit that is already high when reset is released therefore sets its cause after the first clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_i | input | 13 | Level status bits from the SPI controller |
| cause_wr_i | input | 1 | Write strobe for the cause register (write 1 to clear) |
| cause_wdata_i | input | 13 | Write data for the cause register |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| mask_wdata_i | input | 13 | New mask value |
| cause_rd_o | output | 13 | Current latched causes |
| mask_rd_o | output | 13 | Current mask |
| irq_o | output | 1 | Level interrupt line |

## Verification
Directed cases cover single rising edges on chosen bits, a status bit held high across a clear, and a status bit that is high when reset is released. They also cover a set and a clear of the same bit in one cycle, and a zero mask that must silence the interrupt while causes keep latching. Together these separate edge latching from level latching, set-over-clear priority from clear-over-set, and a mask that gates the output from one that gates the latching. Seeded random status toggles, mixed with random clear and mask writes, are then compared every cycle against a bench model. This catches crossed bit positions and write-data bits that land in the wrong place.

// File: rtl/spi_irq_cause_pkg.sv
// Package: shared sizes and bit positions for the SPI interrupt cause unit.
// Assumes the status vector layout is fixed by the controller that drives it.
package spi_irq_cause_pkg;
    localparam int unsigned IRQ_BITS = 13;

    // Bit positions of the status vector (a neighbour decodes these).
    localparam int unsigned POS_XFER_DONE   = 0;
    localparam int unsigned POS_XFER_READY  = 1;
    localparam int unsigned POS_RXQ_READY   = 2;
    localparam int unsigned POS_TXQ_READY   = 3;
    localparam int unsigned POS_RXQ_EMPTY   = 4;
    localparam int unsigned POS_RXQ_FULL    = 5;
    localparam int unsigned POS_TXQ_EMPTY   = 6;
    localparam int unsigned POS_TXQ_FULL    = 7;
    localparam int unsigned POS_RXQ_UNDER   = 8;
    localparam int unsigned POS_RXQ_OVER    = 9;
    localparam int unsigned POS_TXQ_UNDER   = 10;
    localparam int unsigned POS_TXQ_OVER    = 11;
    localparam int unsigned POS_NO_ADDR_CFG = 12;

    typedef logic [IRQ_BITS-1:0] irq_vec_t;
endpackage

// File: rtl/spi_irq_edge_detect.sv
// Module: per-bit rising-edge detector for the level status vector.
// Holds the previous status, which resets to 0, and flags bits that were 0
// at the previous clock edge and are 1 now. Assumes status_i is synchronous to clk.
module spi_irq_edge_detect #(
    parameter int unsigned WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    // Remember the status seen at the last clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= status_i;
    end

    // One detector per bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_comb rise_o[g] = status_i[g] & ~prev_q[g];
    end

    // R3: a bit that was high at the last edge cannot report a rise.
    a_r3_no_rise_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i != '0) |=> ((rise_o & $past(status_i)) == '0));
endmodule

// File: rtl/spi_irq_cause_bank.sv
// Module: sticky cause register with write-one-to-clear.
// A detected rise sets a bit. A clear write with a 1 in that position clears
// it unless a rise arrives in the same cycle, in which case the set wins.
module spi_irq_cause_bank #(
    parameter int unsigned WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_i,
    input  logic             clr_wr_i,
    input  logic [WIDTH-1:0] clr_data_i,
    output logic [WIDTH-1:0] cause_o
);
    logic [WIDTH-1:0] cause_q;
    logic [WIDTH-1:0] clr_w;

    // Qualify the clear pattern with its strobe.
    always_comb clr_w = clr_wr_i ? clr_data_i : '0;

    // Each bit: set on rise, else clear on a one-write, else hold.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          cause_q[g] <= 1'b0;
            else if (rise_i[g])  cause_q[g] <= 1'b1;
            else if (clr_w[g])   cause_q[g] <= 1'b0;
        end

        // R2 / R5: a rise always leaves the bit set, even against a clear.
        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            rise_i[g] |=> cause_q[g]);
        // R4: a clear without a rise empties the bit.
        a_r4_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w[g] && !rise_i[g]) |=> !cause_q[g]);
        // R4: no rise and no clear, no change.
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_w[g] && !rise_i[g]) |=> $stable(cause_q[g]));
    end

    always_comb cause_o = cause_q;
endmodule

// File: rtl/spi_irq_mask_reg.sv
// Module: interrupt enable mask, loaded whole by a write strobe.
// Assumes the bus side presents a full-width value on every write.
module spi_irq_mask_reg #(
    parameter int unsigned WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_o
);
    logic [WIDTH-1:0] mask_q;

    // Load the mask on a write, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i;
    end

    // R8: without a write the mask keeps its value.
    a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_q));

    always_comb mask_o = mask_q;
endmodule

// File: rtl/spi_irq_combine.sv
// Module: gates the causes with the mask and reduces them to one level line.
// Purely combinational. Assumes both inputs come from registers.
module spi_irq_combine #(
    parameter int unsigned WIDTH = 13
) (
    input  logic [WIDTH-1:0] cause_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_o
);
    logic [WIDTH-1:0] live_w;

    // Keep only the causes that are enabled, then OR them together.
    always_comb begin
        live_w = cause_i & mask_i;
        irq_o  = |live_w;
    end
endmodule

// File: rtl/spi_irq_cause.sv
// Module: top of the SPI edge-triggered interrupt cause unit.
// Status rises latch into the causes, software clears them by writing ones,
// and the mask gates them onto irq_o. Uses a synchronous active-low reset.
module spi_irq_cause
    import spi_irq_cause_pkg::*;
#(
    parameter int unsigned WIDTH = IRQ_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_i,
    input  logic             cause_wr_i,
    input  logic [WIDTH-1:0] cause_wdata_i,
    input  logic             mask_wr_i,
    input  logic [WIDTH-1:0] mask_wdata_i,
    output logic [WIDTH-1:0] cause_rd_o,
    output logic [WIDTH-1:0] mask_rd_o,
    output logic             irq_o
);
    logic [WIDTH-1:0] rise_w;
    logic [WIDTH-1:0] cause_w;
    logic [WIDTH-1:0] mask_w;

    spi_irq_edge_detect #(.WIDTH(WIDTH)) u_edge (
        .clk(clk), .rst_n(rst_n), .status_i(status_i), .rise_o(rise_w)
    );

    spi_irq_cause_bank #(.WIDTH(WIDTH)) u_cause (
        .clk(clk), .rst_n(rst_n), .rise_i(rise_w),
        .clr_wr_i(cause_wr_i), .clr_data_i(cause_wdata_i), .cause_o(cause_w)
    );

    spi_irq_mask_reg #(.WIDTH(WIDTH)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i),
        .wdata_i(mask_wdata_i), .mask_o(mask_w)
    );

    spi_irq_combine #(.WIDTH(WIDTH)) u_comb (
        .cause_i(cause_w), .mask_i(mask_w), .irq_o(irq_o)
    );

    always_comb begin
        cause_rd_o = cause_w;
        mask_rd_o  = mask_w;
    end

    // R7: a zero mask keeps the line low.
    a_r7_zero_mask_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '0) |-> !irq_o);
    // R6: a rise latches even when its mask bit is 0.
    a_r6_latch_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_w & ~mask_w) != '0) |=> ((cause_w & $past(rise_w & ~mask_w)) == $past(rise_w & ~mask_w)));
    // R8: a mask write is visible on the readback after the edge.
    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (mask_rd_o == $past(mask_wdata_i)));
endmodule

// File: tb/spi_irq_cause_tb.sv
module spi_irq_cause_tb;
    localparam int W = 13;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] status = '0;
    logic         cwr = 1'b0;
    logic [W-1:0] cwd = '0;
    logic         mwr = 1'b0;
    logic [W-1:0] mwd = '0;
    logic [W-1:0] cause_rd;
    logic [W-1:0] mask_rd;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [W-1:0] m_prev = '0, m_cause = '0, m_mask = '0;

    always #2.5 clk = ~clk;

    spi_irq_cause u_dut (
        .clk(clk), .rst_n(rst_n), .status_i(status),
        .cause_wr_i(cwr), .cause_wdata_i(cwd),
        .mask_wr_i(mwr), .mask_wdata_i(mwd),
        .cause_rd_o(cause_rd), .mask_rd_o(mask_rd), .irq_o(irq)
    );

    function automatic logic [W-1:0] next_cause(logic [W-1:0] c, logic [W-1:0] p,
                                                logic [W-1:0] s, logic wr, logic [W-1:0] d);
        logic [W-1:0] clr = wr ? d : '0;
        return (c & ~clr) | (s & ~p);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs at negedge, advance model at posedge, land at next negedge.
    task automatic step(logic [W-1:0] s, logic cw, logic [W-1:0] cd, logic mw, logic [W-1:0] md);
        status = s; cwr = cw; cwd = cd; mwr = mw; mwd = md;
        @(posedge clk);
        if (!rst_n) begin
            m_prev = '0; m_cause = '0; m_mask = '0;
        end else begin
            m_cause = next_cause(m_cause, m_prev, s, cw, cd);
            if (mw) m_mask = md;
            m_prev = s;
        end
        @(negedge clk);
        cwr = 1'b0; mwr = 1'b0;
    endtask

    task automatic chk_all(string req);
        chk(req, 32'(cause_rd), 32'(m_cause));
        chk(req, 32'(mask_rd), 32'(m_mask));
        chk(req, 32'(irq), 32'(|(m_cause & m_mask)));
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R10: status high while in reset, then released
        step(13'h0001, 1'b0, '0, 1'b0, '0);
        step(13'h0001, 1'b0, '0, 1'b0, '0);
        chk("R1", 32'(cause_rd), 32'h0);
        chk("R1", 32'(mask_rd), 32'h0);
        chk("R1", 32'(irq), 32'h0);
        rst_n = 1'b1;
        step(13'h0001, 1'b0, '0, 1'b0, '0);
        chk("R10", 32'(cause_rd), 32'h0001);
        // R6: latched with mask 0, irq stays low
        chk("R6", 32'(irq), 32'h0);
        // R7: enabling mask raises irq next cycle
        step(13'h0001, 1'b0, '0, 1'b1, 13'h0001);
        chk("R7", 32'(irq), 32'h1);
        chk("R8", 32'(mask_rd), 32'h0001);
        // R3: clear while held high, must stay clear
        step(13'h0001, 1'b1, 13'h1FFF, 1'b0, '0);
        chk("R4", 32'(cause_rd), 32'h0);
        step(13'h0001, 1'b0, '0, 1'b0, '0);
        step(13'h0001, 1'b0, '0, 1'b0, '0);
        chk("R3", 32'(cause_rd), 32'h0);
        chk("R3", 32'(irq), 32'h0);
        step(13'h0000, 1'b0, '0, 1'b0, '0);
        step(13'h0001, 1'b0, '0, 1'b0, '0);
        chk("R3", 32'(cause_rd), 32'h0001);
        // R9: bit 12 (address-not-configured) alone, and bit 3 (write-FIFO ready)
        step(13'h1001, 1'b1, 13'h0001, 1'b0, '0);
        chk("R9", 32'(cause_rd), 32'h1000);
        step(13'h1009, 1'b0, '0, 1'b0, '0);
        chk("R9", 32'(cause_rd), 32'h1008);
        // R4: partial clear leaves zeros untouched
        step(13'h1009, 1'b1, 13'h0008, 1'b0, '0);
        chk("R4", 32'(cause_rd), 32'h1000);
        // R5: rise and clear of bit 5 in one cycle
        step(13'h1029, 1'b1, 13'h0020, 1'b0, '0);
        chk("R5", 32'(cause_rd), 32'h1020);
        // R7: mask 0 silences, causes kept
        step(13'h1029, 1'b0, '0, 1'b1, 13'h1020);
        chk("R7", 32'(irq), 32'h1);
        step(13'h1029, 1'b0, '0, 1'b1, 13'h0000);
        chk("R7", 32'(irq), 32'h0);
        chk("R7", 32'(cause_rd), 32'h1020);
        // R8: full-width mask load
        step(13'h1029, 1'b0, '0, 1'b1, 13'h1FFF);
        chk("R8", 32'(mask_rd), 32'h1FFF);
        chk_all("R2");
        // random phase, R2/R4/R8 against model
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] s = W'($urandom);
            logic cw = ($urandom % 4) == 0;
            logic mw = ($urandom % 6) == 0;
            step(s, cw, W'($urandom), mw, W'($urandom));
            chk_all("R8");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule